// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider and Phase Comparator

This block is the digital core of a frequency-synthesis tuner. A host writes a 16-bit serial word that carries the divide ratio of the loop and three band-switch controls. The ratio is held as its bitwise complement. A divider built from a 4-bit swallow counter and a 9-bit main counter counts the output periods of an external 16/17 prescaler. The divider also drives that prescaler's modulus input, so the VCO is divided by the full 13-bit ratio N.

A fixed divider produces the comparison reference from the crystal clock, which is the block clock. A second fixed divider produces a slower clock output. A phase-frequency comparator matches the end of each divider cycle against each reference event. It drives UP and DOWN requests and an enable for the external charge pump. It also drives an active-low lock flag and a select that moves the pump to its low current range while the loop is locked.

The prescaler output reaches the block as a one-cycle strobe `pre_pulse`, one per prescaler output period, synchronous to `clk`. The serial lines are sampled on `clk`.

Top module: `pll_synth_core`

## Requirements
- R1: A bit on `ser_data` is shifted in on each falling edge of `ser_clk` seen while `ser_en` is high. Bits arrive least significant first. After 16 shifts, word bits 12..0 hold the bitwise complement of the ratio N, and bits 15..13 hold the band controls.
- R2: Only the last 16 bits shifted before `ser_en` goes low take effect. Any earlier bits in the same burst are discarded.
- R3: While `ser_en` is low, the latched word follows the shift register, and falling edges of `ser_clk` shift nothing. While `ser_en` is high, the latched word does not change.
- R4: The band outputs are active low: `band_n[i]` is the inverse of word bit 13+i.
- R5: With M = N[12:4], `carry_o` is high for exactly one cycle after every M-th `pre_pulse`. It follows the strobe that ends a divider cycle, and a newly latched ratio takes effect at the next cycle boundary.
- R6: With A = N[3:0], `mod_ctl` is high (divide by 17) for the first A prescaler periods of each divider cycle and low (divide by 16) for the remaining M−A periods. This needs N ≥ 256.
- R7: `ref_out` is high for 768 cycles and low for 768 cycles (crystal divided by 1536). `clk_out` is a square wave that toggles every 24 cycles (crystal divided by 48).
- R8: When the reference falls first, `up` is high from that edge until the divider cycle ends. When the divider cycle ends first, `dn` is high until the reference falls. Both are low otherwise, never both are high, and `pump_oe` is high exactly while either one is.
- R9: `lock_n` goes low once 4 consecutive comparisons have both edges within one clock cycle of each other. Any comparison with a wider gap drives it high again.
- R10: `i_low` (low pump current range) is high exactly while `lock_n` is low.
- R11: After reset, `up`, `dn`, `pump_oe`, `carry_o`, `mod_ctl` and `i_low` are low, and `lock_n` and all `band_n` bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_en | input | 1 | Shift enable when high, latch when low |
| pre_pulse | input | 1 | One strobe per prescaler output period |
| mod_ctl | output | 1 | Prescaler modulus: 1 = divide by 17 |
| carry_o | output | 1 | Divider-cycle end pulse (test output) |
| ref_out | output | 1 | Comparison reference, falling edge is the event |
| clk_out | output | 1 | Crystal divided by 48 |
| up | output | 1 | Pump up request |
| dn | output | 1 | Pump down request |
| pump_oe | output | 1 | Pump output enable, low means tri-state |
| lock_n | output | 1 | Lock flag, active low |
| i_low | output | 1 | Selects the low pump current range |
| band_n | output | 3 | Band-switch outputs, active low |

## Verification
The embedded properties check the cycle-level invariants on every clock. They check that UP and DOWN are exclusive. They check that UP only rises as the reference falls and DOWN only rises with a carry. They check that the band latch stays still while shifting, that `mod_ctl` only drops on a prescaler strobe, that carry follows a strobe, and that lock is only gained at a comparison. The bench scenarios alone show the counting results: the number of strobes per carry, the number of divide-by-17 periods, the discarding of dummy bits, the reference and clock periods, and the lock count with its one-cycle tolerance window, since each of these needs a whole sequence of cycles compared against the decoded ratio.

// File: rtl/pll_synth_core.sv
module pll_synth_core #(
  parameter int N_W      = 13,
  parameter int A_W      = 4,
  parameter int BAND_W   = 3,
  parameter int REF_DIV  = 1536,
  parameter int CKO_DIV  = 48,
  parameter int LOCK_CNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  input  logic              pre_pulse,
  output logic              mod_ctl,
  output logic              carry_o,
  output logic              ref_out,
  output logic              clk_out,
  output logic              up,
  output logic              dn,
  output logic              pump_oe,
  output logic              lock_n,
  output logic              i_low,
  output logic [BAND_W-1:0] band_n
);
  localparam int TG_W  = N_W + BAND_W;
  localparam int M_W   = N_W - A_W;
  localparam int RHALF = REF_DIV / 2;
  localparam int R_W   = $clog2(REF_DIV);
  localparam int CHALF = CKO_DIV / 2;
  localparam int C_W   = $clog2(CHALF);
  localparam int L_W   = $clog2(LOCK_CNT + 1);

  logic            sck_q;
  logic [TG_W-1:0] sr, lat;
  logic [N_W-1:0]  nval;
  logic [M_W-1:0]  mcnt;
  logic [A_W-1:0]  scnt;
  logic [R_W-1:0]  rcnt;
  logic [C_W-1:0]  ccnt;
  logic [L_W-1:0]  lcnt;
  logic            div_evt, ref_evt, nx_up, nx_dn, clr, fresh, good;

  assign nval    = ~lat[N_W-1:0];
  assign band_n  = ~lat[TG_W-1:N_W];
  assign div_evt = pre_pulse && (mcnt == '0);
  assign mod_ctl = (scnt != '0);
  assign ref_evt = (rcnt == R_W'(RHALF - 1));
  assign ref_out = (rcnt < R_W'(RHALF));
  assign nx_up   = up | ref_evt;
  assign nx_dn   = dn | div_evt;
  assign clr     = nx_up & nx_dn;
  assign good    = clr & ((ref_evt & div_evt & ~up & ~dn) | fresh);
  assign pump_oe = up | dn;
  assign lock_n  = (lcnt != L_W'(LOCK_CNT));
  assign i_low   = ~lock_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0;
      sr    <= '0;
      lat   <= '0;
    end else begin
      sck_q <= ser_clk;
      if (ser_en && sck_q && !ser_clk) sr <= {ser_data, sr[TG_W-1:1]};
      if (!ser_en) lat <= sr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mcnt    <= '0;
      scnt    <= '0;
      carry_o <= 1'b0;
    end else begin
      carry_o <= div_evt;
      if (div_evt) begin
        mcnt <= nval[N_W-1:A_W] - M_W'(1);
        scnt <= nval[A_W-1:0];
      end else if (pre_pulse) begin
        mcnt <= mcnt - M_W'(1);
        if (scnt != '0) scnt <= scnt - A_W'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcnt    <= '0;
      ccnt    <= '0;
      clk_out <= 1'b0;
    end else begin
      rcnt <= (rcnt == R_W'(REF_DIV - 1)) ? '0 : rcnt + R_W'(1);
      if (ccnt == C_W'(CHALF - 1)) begin
        ccnt    <= '0;
        clk_out <= ~clk_out;
      end else begin
        ccnt <= ccnt + C_W'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up    <= 1'b0;
      dn    <= 1'b0;
      fresh <= 1'b0;
      lcnt  <= '0;
    end else begin
      up    <= nx_up & ~clr;
      dn    <= nx_dn & ~clr;
      fresh <= (nx_up ^ nx_dn) & ~up & ~dn;
      if (clr) begin
        if (!good) lcnt <= '0;
        else if (lcnt != L_W'(LOCK_CNT)) lcnt <= lcnt + L_W'(1);
      end
    end

  // R3
  band_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ser_en) |-> $stable(band_n));
  // R5
  carry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> $past(pre_pulse));
  // R6
  mod_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_ctl) |-> $past(pre_pulse));
  // R8
  up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));
  // R8
  up_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $fell(ref_out));
  // R8
  dn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn) |-> carry_o);
  // R9
  lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> ($fell(ref_out) || carry_o));
endmodule

// File: tb/tb_pll_synth_core.sv
module tb_pll_synth_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b1, ser_data = 1'b0, ser_en = 1'b0, pre_pulse = 1'b0;
  logic mod_ctl, carry_o, ref_out, clk_out, up, dn, pump_oe, lock_n, i_low;
  logic [2:0] band_n;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  pll_synth_core dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .pre_pulse(pre_pulse), .mod_ctl(mod_ctl), .carry_o(carry_o),
    .ref_out(ref_out), .clk_out(clk_out), .up(up), .dn(dn), .pump_oe(pump_oe),
    .lock_n(lock_n), .i_low(i_low), .band_n(band_n));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  localparam int NV = 5;
  localparam int TV_N [NV] = '{256, 261, 300, 1000, 8191};
  localparam int TV_B [NV] = '{1, 2, 4, 0, 7};
  localparam int TV_D [NV] = '{0, 3, 0, 5, 0};

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int n, int band, int dummies);
    logic [15:0] w;
    w = {band[2:0], ~n[12:0]};
    ser_en = 1'b1;
    for (int i = 0; i < dummies + 16; i++) begin
      @(negedge clk);
      ser_data = (i < dummies) ? 1'b1 : w[i - dummies];
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    ser_clk = 1'b1;
    ser_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    pre_pulse = 1'b1;
    @(negedge clk);
    pre_pulse = 1'b0;
  endtask

  task automatic wait_until(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse_at(int t);
    wait_until(t - 1);
    pre_pulse = 1'b1;
    @(negedge clk);
    pre_pulse = 1'b0;
  endtask

  task automatic pulses15(int start);
    for (int k = 1; k <= 15; k++) pulse_at(start + 96 * k);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base, a, n, m, hi;
    logic prev;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 up", up, 0);        check("R11 dn", dn, 0);
    check("R11 pump_oe", pump_oe, 0); check("R11 carry", carry_o, 0);
    check("R11 mod_ctl", mod_ctl, 0); check("R11 i_low", i_low, 0);
    check("R11 lock_n", lock_n, 1);   check("R11 band_n", band_n, 7);
    rst_n = 1'b1;

    // R1 R2 R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      send(TV_N[v], TV_B[v], TV_D[v]);
      check("R4 band_n", band_n, (~TV_B[v]) & 7);
      do pulse(); while (carry_o !== 1'b1);
      m = 0; hi = 0;
      do begin
        if (mod_ctl) hi++;
        pulse();
        m++;
      end while (carry_o !== 1'b1 && m < 9000);
      check("R5 strobes per carry", m, TV_N[v] >> 4);
      check("R6 divide-by-17 periods", hi, TV_N[v] & 15);
      @(negedge clk);
      check("R5 carry one cycle", carry_o, 0);
    end

    // R3: shift clocks with enable low are ignored
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ser_data = i[0]; ser_clk = 1'b0;
      repeat (2) @(negedge clk); ser_clk = 1'b1;
    end
    repeat (3) @(negedge clk);
    check("R3 band_n after ignored shifts", band_n, 0);

    // R7: clk_out and ref_out high runs
    prev = clk_out;
    do begin prev = clk_out; @(negedge clk); end while (!(prev == 1'b0 && clk_out == 1'b1));
    n = 0;
    while (clk_out == 1'b1) begin n++; @(negedge clk); end
    check("R7 clk_out half period", n, 24);
    do begin prev = ref_out; @(negedge clk); end while (!(prev == 1'b0 && ref_out == 1'b1));
    n = 0;
    while (ref_out == 1'b1) begin n++; @(negedge clk); end
    check("R7 ref_out high time", n, 768);

    // lock scenarios with N = 256 (16 strobes per cycle)
    send(256, 0, 0);
    do pulse(); while (carry_o !== 1'b1);
    do begin prev = ref_out; @(negedge clk); end while (!(prev == 1'b1 && ref_out == 1'b0));
    base = cyc;

    // R8: reference first -> up
    a = base + 1536;
    pulses15(base);
    wait_until(a + 5);
    check("R8 up while late", up, 1); check("R8 dn while late", dn, 0);
    check("R8 pump_oe while late", pump_oe, 1);
    pulse_at(a + 10);
    check("R8 up cleared", up, 0); check("R8 pump_oe tri-state", pump_oe, 0);

    // R9 R10: four aligned comparisons
    for (int j = 2; j <= 5; j++) begin
      pulses15(base + 1536 * (j - 1));
      pulse_at(base + 1536 * j);
      if (j == 4) begin
        check("R9 not locked after 3", lock_n, 1);
        check("R10 high range after 3", i_low, 0);
      end
    end
    check("R9 locked after 4", lock_n, 0);
    check("R10 low range in lock", i_low, 1);

    // R9: one-cycle gap still counts
    a = base + 1536 * 6;
    pulses15(base + 1536 * 5);
    pulse_at(a - 1);
    check("R8 dn when divider first", dn, 1);
    wait_until(a);
    check("R8 dn cleared by reference", dn, 0);
    check("R9 stays locked at one-cycle gap", lock_n, 0);

    // R8 R9 R10: wide early gap drops lock
    a = base + 1536 * 7;
    pulses15(base + 1536 * 6);
    pulse_at(a - 10);
    wait_until(a - 5);
    check("R8 dn while early", dn, 1); check("R8 up while early", up, 0);
    wait_until(a);
    check("R8 dn end", dn, 0);
    check("R9 lock lost", lock_n, 1);
    check("R10 high range restored", i_low, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule